// File: doc/BRIEF.md
# Dual-Mode Video Serial-Link Encoder

This block sits in front of a 10-bit serializer and prepares one character per clock, at one tenth of the serial bit rate. The character is captured on the rising clock edge and leaves in a single output register one clock later. An active-low mode input, sampled on every edge, selects between two datapaths for the word captured on that edge.

With the mode input high (video mode), all ten input bits are scrambled and then NRZI coded, one bit at a time and least significant bit first. The scrambler is self-synchronizing with polynomial x^9 + x^4 + 1. The NRZI stage applies x + 1. Both stages carry their state from one word to the next. With the mode input low (transport mode), the middle eight bits pass through unchanged. The top and bottom bits become two flags, a violation-symbol flag and a special-character flag. Each flag can be forced low by its own enable.

An active-low data-valid output tells the serializer which words carry data. An output-enable input releases every output to high impedance.

Top module: `vsl_encoder`

## Requirements
- R1: While reset is asserted, and until the first word is captured after release, the output word is all zeros, the data-valid output is 1 (not valid), and the scrambler and NRZI states are zero.
- R2: In transport mode (mode input 0), output bits 8..1 equal input bits 8..1 as captured on the previous rising edge.
- R3: In transport mode, output bit 9 is the captured input bit 9 when the violation-flag enable was 1 at capture, and 0 when it was 0.
- R4: In transport mode, output bit 0 is the captured input bit 0 when the special-flag enable was 1 at capture, and 0 (data only) when it was 0.
- R5: In video mode (mode input 1), the word is processed bit by bit from bit 0 to bit 9. Each bit is scrambled as y = x xor s[3] xor s[8], where s[k] is the scrambled bit from k+1 bit-times earlier. It is then NRZI coded as z = y xor (previous z). Output bit i is z for input bit i, and both states carry across consecutive video words.
- R6: In transport mode, the data-valid output equals the active-low valid input captured on the previous edge.
- R7: In video mode, the data-valid output is 0 (valid) on the following cycle.
- R8: When output enable is 0, the output word and the data-valid output are high impedance. When it is 1, they drive the registered values.
- R9: Transport-mode words leave the scrambler and NRZI states unchanged, so a video word that follows continues the earlier video sequence.
- R10: Latency is exactly one clock in both modes. The mode in effect for a word is the mode input sampled on the same edge that captures it, so switching modes takes effect on the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_n | input | 1 | 0 = transport pass-through, 1 = video scramble and NRZI |
| vflag_en | input | 1 | Enables the violation flag (bit 9) in transport mode |
| sflag_en | input | 1 | Enables the special-character flag (bit 0) in transport mode |
| din | input | 10 | Input character |
| valid_in_n | input | 1 | Active-low valid input, latched in transport mode |
| oe | input | 1 | Output enable; 0 puts every output at high impedance |
| dout | output | 10 | Registered output character |
| dvalid_n | output | 1 | Active-low data-valid output |

## Verification
The bench builds the block with its default parameters: a 10-bit word and a 9-stage scrambler with its tap after stage 4. At this size a bench function can compute the exact serial scramble-and-NRZI stream, so every output word is compared bit for bit. Random words are mixed with abrupt mode switches, so a scrambler state held across a transport-mode stretch (R9) and a mode change at a single edge (R10) are both exercised. Directed cases cover each flag enable at both levels, an all-zero video word straight after reset, and the bus released to high impedance.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
  localparam int unsigned DEF_WORD_W  = 10;
  localparam int unsigned DEF_SCR_LEN = 9;
  localparam int unsigned DEF_SCR_TAP = 4;

  typedef struct packed {
    logic mode_n;
    logic vflag_en;
    logic sflag_en;
    logic valid_n;
  } ctl_t;
endpackage

// File: rtl/vsl_rst_sync.sv
module vsl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_r[STAGES-1];
endmodule

// File: rtl/vsl_scr_nrzi.sv
module vsl_scr_nrzi #(
  parameter int unsigned WORD_W  = vsl_pkg::DEF_WORD_W,
  parameter int unsigned SCR_LEN = vsl_pkg::DEF_SCR_LEN,
  parameter int unsigned SCR_TAP = vsl_pkg::DEF_SCR_TAP
) (
  input  logic [WORD_W-1:0]  word_in,
  input  logic [SCR_LEN-1:0] scr_cur,
  input  logic               nrz_cur,
  output logic [WORD_W-1:0]  word_out,
  output logic [SCR_LEN-1:0] scr_nxt,
  output logic               nrz_nxt
);
  // One slice per bit, LSB first; states ripple through the chain.
  logic [SCR_LEN-1:0] scr_chain [WORD_W+1];
  logic               nrz_chain [WORD_W+1];
  logic [WORD_W-1:0]  scr_bit;

  assign scr_chain[0] = scr_cur;
  assign nrz_chain[0] = nrz_cur;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign scr_bit[i]      = word_in[i] ^ scr_chain[i][SCR_TAP-1] ^ scr_chain[i][SCR_LEN-1];
    assign scr_chain[i+1]  = {scr_chain[i][SCR_LEN-2:0], scr_bit[i]};
    assign nrz_chain[i+1]  = scr_bit[i] ^ nrz_chain[i];
    assign word_out[i]     = nrz_chain[i+1];
  end

  assign scr_nxt = scr_chain[WORD_W];
  assign nrz_nxt = nrz_chain[WORD_W];
endmodule

// File: rtl/vsl_encoder.sv
module vsl_encoder #(
  parameter int unsigned WORD_W  = vsl_pkg::DEF_WORD_W,
  parameter int unsigned SCR_LEN = vsl_pkg::DEF_SCR_LEN,
  parameter int unsigned SCR_TAP = vsl_pkg::DEF_SCR_TAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_n,
  input  logic              vflag_en,
  input  logic              sflag_en,
  input  logic [WORD_W-1:0] din,
  input  logic              valid_in_n,
  input  logic              oe,
  output logic [WORD_W-1:0] dout,
  output logic              dvalid_n
);
  import vsl_pkg::*;

  localparam int unsigned MID_W = WORD_W - 2;
  localparam int unsigned MSB   = WORD_W - 1;

  logic               rst_q_n;
  ctl_t               ctl;
  logic [WORD_W-1:0]  coded;
  logic [SCR_LEN-1:0] scr_state, scr_calc, scr_d;
  logic               nrz_state, nrz_calc, nrz_d;
  logic               state_en;
  logic [WORD_W-1:0]  q_word, q_word_d;
  logic               q_valid_n, q_valid_d;

  vsl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign ctl = '{mode_n: mode_n, vflag_en: vflag_en, sflag_en: sflag_en, valid_n: valid_in_n};

  vsl_scr_nrzi #(.WORD_W(WORD_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_code (
    .word_in  (din),
    .scr_cur  (scr_state),
    .nrz_cur  (nrz_state),
    .word_out (coded),
    .scr_nxt  (scr_calc),
    .nrz_nxt  (nrz_calc)
  );

  // Next-state logic
  always_comb begin
    state_en = ctl.mode_n;
    scr_d    = scr_state;
    nrz_d    = nrz_state;
    if (state_en) begin
      scr_d = scr_calc;
      nrz_d = nrz_calc;
    end
    if (ctl.mode_n) begin
      q_word_d  = coded;
      q_valid_d = 1'b0;
    end else begin
      q_word_d            = '0;
      q_word_d[MSB-1:1]   = din[MSB-1:1];
      q_word_d[MSB]       = ctl.vflag_en & din[MSB];
      q_word_d[0]         = ctl.sflag_en & din[0];
      q_valid_d           = ctl.valid_n;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      scr_state <= '0;
      nrz_state <= 1'b0;
    end else if (state_en) begin
      scr_state <= scr_d;
      nrz_state <= nrz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      q_word    <= '0;
      q_valid_n <= 1'b1;
    end else begin
      q_word    <= q_word_d;
      q_valid_n <= q_valid_d;
    end
  end

  if (MID_W < 1) begin : g_bad_width
    initial $error("WORD_W must be at least 3");
  end

  assign dout     = oe ? q_word    : {WORD_W{1'bz}};
  assign dvalid_n = oe ? q_valid_n : 1'bz;
endmodule

// File: rtl/vsl_encoder_chk.sv
module vsl_encoder_chk #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned SCR_LEN = 9
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               mode_n,
  input logic               vflag_en,
  input logic               sflag_en,
  input logic [WORD_W-1:0]  din,
  input logic               valid_in_n,
  input logic               oe,
  input logic [WORD_W-1:0]  dout,
  input logic [WORD_W-1:0]  q_word,
  input logic               q_valid_n,
  input logic [SCR_LEN-1:0] scr_state,
  input logic               nrz_state
);
  assert_mid_pass_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mode_n |=> q_word[WORD_W-2:1] == $past(din[WORD_W-2:1]));

  assert_vflag_off_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mode_n && !vflag_en) |=> !q_word[WORD_W-1]);

  assert_vflag_on_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mode_n && vflag_en) |=> q_word[WORD_W-1] == $past(din[WORD_W-1]));

  assert_sflag_off_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mode_n && !sflag_en) |=> !q_word[0]);

  assert_valid_pass_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mode_n |=> q_valid_n == $past(valid_in_n));

  assert_valid_video_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    mode_n |=> !q_valid_n);

  assert_drive_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    oe |-> dout == q_word);

  assert_state_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mode_n |=> ($stable(scr_state) && $stable(nrz_state)));
endmodule

bind vsl_encoder vsl_encoder_chk #(.WORD_W(WORD_W), .SCR_LEN(SCR_LEN)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .mode_n     (mode_n),
  .vflag_en   (vflag_en),
  .sflag_en   (sflag_en),
  .din        (din),
  .valid_in_n (valid_in_n),
  .oe         (oe),
  .dout       (dout),
  .q_word     (q_word),
  .q_valid_n  (q_valid_n),
  .scr_state  (scr_state),
  .nrz_state  (nrz_state)
);

// File: tb/tb_vsl_encoder.sv
`timescale 1ns/1ps
module tb_vsl_encoder;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_n, vflag_en, sflag_en, valid_in_n, oe;
  logic [W-1:0] din;
  wire  [W-1:0] dout;
  wire          dvalid_n;

  int errors = 0;
  int checks = 0;

  logic [8:0] m_scr;
  logic       m_nrz;

  always #4 clk = ~clk;

  for (genvar k = 0; k < W; k++) begin : g_pu
    pullup (dout[k]);
  end
  pullup (dvalid_n);

  vsl_encoder dut (
    .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .vflag_en(vflag_en),
    .sflag_en(sflag_en), .din(din), .valid_in_n(valid_in_n), .oe(oe),
    .dout(dout), .dvalid_n(dvalid_n)
  );

  function automatic logic [W-1:0] video_word(input logic [W-1:0] x);
    logic [W-1:0] r;
    logic y;
    for (int i = 0; i < W; i++) begin
      y     = x[i] ^ m_scr[3] ^ m_scr[8];
      m_scr = {m_scr[7:0], y};
      m_nrz = y ^ m_nrz;
      r[i]  = m_nrz;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] pass_word(input logic [W-1:0] x, input logic ve, input logic se);
    logic [W-1:0] r;
    r       = x;
    r[W-1]  = ve & x[W-1];
    r[0]    = se & x[0];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one word at the falling edge, check one clock later (R10 latency).
  task automatic step(input string req, input logic m, input logic ve, input logic se,
                      input logic [W-1:0] d, input logic vin, input logic en);
    logic [W-1:0] ew;
    logic         ev;
    @(negedge clk);
    mode_n = m; vflag_en = ve; sflag_en = se; din = d; valid_in_n = vin; oe = en;
    if (m) begin ew = video_word(d); ev = 1'b0; end
    else   begin ew = pass_word(d, ve, se); ev = vin; end
    @(posedge clk); #1;
    if (en) begin
      check(req, dout, ew);
      check(req, {{(W-1){1'b0}}, dvalid_n}, {{(W-1){1'b0}}, ev});
    end else begin
      check(req, dout, {W{1'b1}});
      check(req, {{(W-1){1'b0}}, dvalid_n}, {{(W-1){1'b0}}, 1'b1});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_scr = '0; m_nrz = 1'b0;
    rst_n = 1'b0; mode_n = 1'b0; vflag_en = 1'b0; sflag_en = 1'b0;
    din = '0; valid_in_n = 1'b1; oe = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", dout, '0);
    check("R1 reset valid", {{(W-1){1'b0}}, dvalid_n}, {{(W-1){1'b0}}, 1'b1});
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", dout, '0);

    // R5/R1: zero word from zero state stays zero, then a single one bit
    step("R5 zero word", 1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1);
    step("R5 single bit", 1'b1, 1'b0, 1'b0, 10'h001, 1'b1, 1'b1);
    step("R5 all ones", 1'b1, 1'b0, 1'b0, 10'h3FF, 1'b1, 1'b1);
    step("R7 video valid", 1'b1, 1'b1, 1'b1, 10'h155, 1'b1, 1'b1);
    // R3/R4 flag enables at both levels
    step("R3 vflag off", 1'b0, 1'b0, 1'b1, 10'h3FF, 1'b0, 1'b1);
    step("R3 vflag on",  1'b0, 1'b1, 1'b0, 10'h3FF, 1'b0, 1'b1);
    step("R4 sflag off", 1'b0, 1'b1, 1'b0, 10'h201, 1'b1, 1'b1);
    step("R4 sflag on",  1'b0, 1'b0, 1'b1, 10'h001, 1'b0, 1'b1);
    step("R2 mid bits",  1'b0, 1'b0, 1'b0, 10'h1FE, 1'b0, 1'b1);
    step("R6 valid in",  1'b0, 1'b1, 1'b1, 10'h0AA, 1'b1, 1'b1);
    // R9: state held across transport words
    step("R9 resume video", 1'b1, 1'b0, 1'b0, 10'h2C3, 1'b1, 1'b1);
    // R10: single-edge mode switches
    step("R10 to pass", 1'b0, 1'b1, 1'b1, 10'h3C3, 1'b0, 1'b1);
    step("R10 to video", 1'b1, 1'b1, 1'b1, 10'h3C3, 1'b0, 1'b1);
    // R8: released bus reads the pull-ups
    step("R8 hiz", 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0);
    step("R8 drive again", 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b1);

    for (int n = 0; n < 600; n++) begin
      logic m;
      m = ($urandom % 4) != 0;
      step(m ? "R5 random video" : "R2 random pass", m, 1'($urandom), 1'($urandom),
           W'($urandom), 1'($urandom), ($urandom % 16) != 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule